// File: doc/BRIEF.md
# Time-Sliced Serial Bus Master

This block drives one end of a shared, bidirectional, single-wire serial bus. It serves a fixed set of slave nodes. Master and slaves run from one common clock, so no bus clock travels with the data. Every bit lasts exactly eight system clocks. A slave is never addressed by a field in the frame. It knows its turn only from its position after the slice strobe, a separate output that the master raises once per slice.

A slice is made of three parts. First the strobe is high for one bit time. Then come two bit times in which the line is driven low. Last come the slots, one per slave, always in ascending slot order. Each slot is 36 bit times long: a frame of one start bit and 32 data bits, then three guard bits for line turnaround. Each slot has a direction. In a downstream slot the master drives the word held for that slot. In an upstream slot the master releases the line and captures the word the slave sends. A slot whose start bit does not arrive raises a timeout flag for that slot.

Words sit in a small per-slot array. The array is loaded through a write port and read through a combinational read port. Slices follow one another back to back for as long as `run` stays high.

Top module: `tsbus_master`

## Requirements
- R1: After reset, `strobe` is 0, the line is driven (`data_oe`=1) with `data_o`=0, all `tmo` flags are 0 and every slot word reads 0.
- R2: When `run` is 1 while the block is idle, a slice begins and `strobe` is 1 for exactly 8 consecutive clocks, then 0 for the rest of the slice.
- R3: During the strobe bit and the two bit times after it, the line is driven low (`data_oe`=1, `data_o`=0). The start bit of slot 0 begins 24 clocks after `strobe` rises.
- R4: Slots follow in order 0 to N_SLOTS-1. Each slot is 36 bit times (288 clocks) long, so slot s begins 24+288*s clocks after `strobe` rises.
- R5: In a downstream slot (`cfg_dir[s]`=0), bit 0 is a 1 (the start bit) and bits 1..32 carry word bits 0..31, least significant bit first. Each bit lasts 8 clocks and `data_oe` is 1 for all 33 bits.
- R6: In the three guard bits (bits 33..35) of a downstream slot, `data_oe` is 0.
- R7: In an upstream slot (`cfg_dir[s]`=1), `data_oe` is 0 for all 36 bit times.
- R8: In an upstream slot, `data_i` is sampled at clock 4 of each bit. If the start bit reads 1, the next 32 bits are stored, least significant bit first, as the slot word (readable on `rd_data`), and `tmo[s]` is cleared.
- R9: In an upstream slot whose start bit reads 0, `tmo[s]` becomes 1 and the stored slot word keeps its previous value.
- R10: After the last slot, if `run` is 0 the block goes idle (`strobe` 0, line driven low). If `run` is 1, the next strobe starts on the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the slaves |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start or continue slices |
| cfg_dir | input | N_SLOTS | Per-slot direction, 1 = upstream |
| wr_en | input | 1 | Write `wr_data` into slot `wr_slot` |
| wr_slot | input | log2(N_SLOTS) | Slot index for writing |
| wr_data | input | WORD_W | Word to store |
| rd_slot | input | log2(N_SLOTS) | Slot index for reading |
| rd_data | output | WORD_W | Stored word of `rd_slot` |
| strobe | output | 1 | Start-of-slice strobe |
| data_o | output | 1 | Line value when driving |
| data_oe | output | 1 | Line driver enable |
| data_i | input | 1 | Line value as received |
| tmo | output | N_SLOTS | Per-slot missing-start-bit flags |

## Verification
A bit counter that is off by one moves every later bit and slot. The bench reconstructs whole words from mid-bit samples, so such an error shows up as a wrong downstream word or a strobe of the wrong length within the first slice. A slot index that skips or repeats puts one slot's word into another's position. Slot words are distinct, so this is visible at the next downstream check. A wrong capture state shows up within one slice, either as a corrupted word on `rd_data`, a stored word that changed after a missing start bit, or a `tmo` flag with the wrong value.

// File: rtl/tsbus_master.sv
module tsbus_master #(
  parameter int N_SLOTS    = 4,
  parameter int WORD_W     = 32,
  parameter int BIT_CLKS   = 8,
  parameter int SAMPLE_AT  = 4,
  parameter int LEAD_BITS  = 2,
  parameter int GUARD_BITS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic [N_SLOTS-1:0]         cfg_dir,
  input  logic                       wr_en,
  input  logic [$clog2(N_SLOTS)-1:0] wr_slot,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [$clog2(N_SLOTS)-1:0] rd_slot,
  output logic [WORD_W-1:0]          rd_data,
  output logic                       strobe,
  output logic                       data_o,
  output logic                       data_oe,
  input  logic                       data_i,
  output logic [N_SLOTS-1:0]         tmo
);
  localparam int FRAME_BITS = WORD_W + 1;
  localparam int SLOT_BITS  = FRAME_BITS + GUARD_BITS;
  localparam int CW = $clog2(BIT_CLKS);
  localparam int BW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(N_SLOTS);
  localparam int IW = $clog2(WORD_W);

  typedef enum logic [1:0] {IDLE, STRB, LEAD, SLOT} phase_t;

  phase_t            phase;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bitn;
  logic [SW-1:0]     slot;
  logic [WORD_W-2:0] sh;
  logic              ok;
  logic [WORD_W-1:0] mem [N_SLOTS];
  logic [IW-1:0]     didx;

  wire bit_end = cnt == CW'(BIT_CLKS - 1);
  wire up_slot = phase == SLOT && cfg_dir[slot];
  wire smp     = up_slot && cnt == CW'(SAMPLE_AT);
  assign didx  = IW'(bitn - BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= IDLE;
      cnt   <= '0;
      bitn  <= '0;
      slot  <= '0;
    end else if (phase == IDLE) begin
      cnt  <= '0;
      bitn <= '0;
      slot <= '0;
      if (run) phase <= STRB;
    end else begin
      cnt <= bit_end ? '0 : cnt + CW'(1);
      if (bit_end) begin
        case (phase)
          STRB: begin
            phase <= LEAD;
            bitn  <= '0;
          end
          LEAD: begin
            if (bitn == BW'(LEAD_BITS - 1)) begin
              phase <= SLOT;
              bitn  <= '0;
              slot  <= '0;
            end else begin
              bitn <= bitn + BW'(1);
            end
          end
          default: begin
            if (bitn == BW'(SLOT_BITS - 1)) begin
              bitn <= '0;
              if (slot == SW'(N_SLOTS - 1)) begin
                slot  <= '0;
                phase <= run ? STRB : IDLE;
              end else begin
                slot <= slot + SW'(1);
              end
            end else begin
              bitn <= bitn + BW'(1);
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmo <= '0;
      ok  <= 1'b0;
      sh  <= '0;
      for (int i = 0; i < N_SLOTS; i++) mem[i] <= '0;
    end else begin
      if (wr_en) mem[wr_slot] <= wr_data;
      if (smp) begin
        if (bitn == '0) begin
          ok        <= data_i;
          tmo[slot] <= !data_i;
        end else if (ok && bitn < BW'(WORD_W)) begin
          sh <= {data_i, sh[WORD_W-2:1]};
        end else if (ok && bitn == BW'(WORD_W)) begin
          mem[slot] <= {data_i, sh};
        end
      end
    end
  end

  assign strobe  = phase == STRB;
  assign data_oe = !(phase == SLOT && (cfg_dir[slot] || bitn >= BW'(FRAME_BITS)));
  assign data_o  = data_oe && phase == SLOT &&
                   (bitn == '0 || (bitn < BW'(FRAME_BITS) && mem[slot][didx]));
  assign rd_data = mem[rd_slot];

  logic [CW:0] sc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc <= '0;
    else        sc <= strobe ? sc + (CW+1)'(1) : '0;
  end

  p_strobe_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> sc < (CW+1)'(BIT_CLKS));
  p_strobe_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> sc == (CW+1)'(BIT_CLKS));
  p_start_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_o |-> data_oe && !strobe);
  p_release_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> phase == SLOT);
  p_tmo_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmo) |-> $past(smp && bitn == '0));
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(rd_slot) && !$past(wr_en) && !$past(smp)) |-> $stable(rd_data));
endmodule

// File: tb/test_tsbus_master.sv
`timescale 1ns/1ps
module test_tsbus_master;
  localparam int SLICE_CLK = (3 + 4 * 36) * 8;

  logic        clk = 0, rst_n = 0, run = 0, wr_en = 0, data_i = 0;
  logic [3:0]  cfg_dir = '0;
  logic [1:0]  wr_slot = '0, rd_slot = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        strobe, data_o, data_oe;
  logic [3:0]  tmo;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] stored [4];
  logic [31:0] up_w [4];

  always #5 clk = ~clk;

  tsbus_master i_tsbus_master (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_dir(cfg_dir),
    .wr_en(wr_en), .wr_slot(wr_slot), .wr_data(wr_data),
    .rd_slot(rd_slot), .rd_data(rd_data), .strobe(strobe),
    .data_o(data_o), .data_oe(data_oe), .data_i(data_i), .tmo(tmo)
  );

  task automatic chk(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_word(input int s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_slot = 2'(s); wr_data = d;
    @(negedge clk);
    wr_en = 0;
    stored[s] = d;
  endtask

  task automatic run_slice(input logic [3:0] dir, input logic [3:0] pres, input bit keep);
    logic [31:0] rec [4];
    bit dn_ok [4];
    bit oe_ok [4];
    bit sok = 1, lok = 1;
    int w = 0;
    cfg_dir = dir;
    run = 1;
    while (!strobe && w < 2000) begin @(negedge clk); w++; end
    for (int s = 0; s < 4; s++) begin rec[s] = '0; dn_ok[s] = 1; oe_ok[s] = 1; end
    for (int c = 0; c < SLICE_CLK; c++) begin
      int g = c / 8;
      int m = c % 8;
      if (c > 0) @(negedge clk);
      if (g < 3) begin
        if (g == 1 && !keep) run = 0;
        if (strobe != (g == 0)) sok = 0;
        if (m == 4 && (!data_oe || data_o)) lok = 0;
      end else begin
        int s = (g - 3) / 36;
        int j = (g - 3) % 36;
        if (m == 0)
          data_i = dir[s] && pres[s] && j < 33 && ((j == 0) ? 1'b1 : up_w[s][(j == 0) ? 0 : j - 1]);
        if (m == 4) begin
          if (dir[s]) begin
            if (data_oe) oe_ok[s] = 0;
          end else if (j < 33) begin
            if (!data_oe) dn_ok[s] = 0;
            if (j == 0) begin
              if (!data_o) dn_ok[s] = 0;
            end else rec[s][j-1] = data_o;
          end else if (data_oe) oe_ok[s] = 0;
        end
      end
    end
    data_i = 0;
    chk(sok, "R2 strobe length", 32'(sok), 1);
    chk(lok, "R3 lead bits low", 32'(lok), 1);
    for (int s = 0; s < 4; s++) begin
      rd_slot = 2'(s);
      #1;
      if (dir[s]) begin
        chk(oe_ok[s], "R7 upstream release", 32'(oe_ok[s]), 1);
        if (pres[s]) begin
          stored[s] = up_w[s];
          chk(rd_data == up_w[s], "R8 captured word", rd_data, up_w[s]);
          chk(tmo[s] == 0, "R8 timeout cleared", 32'(tmo[s]), 0);
        end else begin
          chk(rd_data == stored[s], "R9 word kept", rd_data, stored[s]);
          chk(tmo[s] == 1, "R9 timeout set", 32'(tmo[s]), 1);
        end
      end else begin
        chk(dn_ok[s] && rec[s] == stored[s], (s == 0) ? "R3 R4 R5 slot0 word" : "R4 R5 slot word", rec[s], stored[s]);
        chk(oe_ok[s], "R6 guard release", 32'(oe_ok[s]), 1);
      end
    end
    if (keep) begin
      @(negedge clk);
      chk(strobe == 1, "R10 back-to-back strobe", 32'(strobe), 1);
      run = 0;
      repeat (SLICE_CLK + 20) @(negedge clk);
    end else begin
      repeat (4) @(negedge clk);
      chk(strobe == 0 && data_oe == 1 && data_o == 0, "R10 idle after slice",
          {29'd0, strobe, data_oe, data_o}, 32'b010);
    end
  endtask

  task automatic test_reset;
    @(negedge clk);
    chk(strobe == 0 && data_oe == 1 && data_o == 0, "R1 line state", {29'd0, strobe, data_oe, data_o}, 32'b010);
    chk(tmo == 0, "R1 timeout flags", 32'(tmo), 0);
    rd_slot = 2'd2; #1;
    chk(rd_data == 0, "R1 slot word", rd_data, 0);
  endtask

  task automatic test_mixed_slice;
    up_w[1] = 32'hC3A5_0F1E;
    up_w[3] = 32'h1234_5678;
    run_slice(4'b1010, 4'b0010, 0);
  endtask

  task automatic test_swapped_dirs;
    up_w[0] = 32'h8000_0001;
    up_w[2] = 32'h7E5A_A5E7;
    run_slice(4'b0101, 4'b0101, 0);
  endtask

  task automatic test_recover_back_to_back;
    up_w[3] = 32'hFEDC_BA98;
    run_slice(4'b1000, 4'b1000, 1);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin stored[i] = '0; up_w[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    wr_word(0, 32'hA0A1_0001);
    wr_word(1, 32'hB1B2_0203);
    wr_word(2, 32'hC2C3_0405);
    wr_word(3, 32'hD3D4_0607);
    test_mixed_slice();
    test_swapped_dirs();
    test_recover_back_to_back();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule